// File: doc/BRIEF.md
# Two-Level DMA Issue Scheduler

This block picks which DMA channel issues the next bus transfer. Every cycle is one issue slot. Each channel supplies a ready flag and a priority bit. The scheduler answers with a valid strobe and a one-hot grant, and it issues at most one grant per slot.

Scheduling runs in rounds. A round first serves every ready high-priority channel once, in ascending index order. It then admits exactly one ready low-priority channel and starts again. Low-priority channels take turns through their own rotating pointer, which survives from one round to the next. When no high-priority channel is waiting, low-priority channels are granted back to back. When no low-priority channel is waiting, the high-priority group simply starts a new round.

The priority bit only changes the order in which channels are issued. Bus priority is decided elsewhere. The bit is expected to be cleared at power-up, which gives a plain round robin over all channels.

Top module: `dma_issue_sched`

## Requirements
- R1: While reset is asserted, grantValid is 0 and grantOneHot is all zeros. After reset, the round pointer and the low-priority pointer both start at channel 0.
- R2: grantOneHot has at most one bit set. That bit belongs to a channel whose ready flag is 1. grantValid is 1 exactly when a bit is set.
- R3: grantValid is 0 in any slot where no channel is ready. It is 1 in every slot where at least one channel is ready, so no slot is left idle.
- R4: Within a round, the ready high-priority channels (priority bit 1) are granted in ascending index order, each at most once.
- R5: Once no high-priority channel remains ahead of the round pointer, exactly one ready low-priority channel (priority bit 0) is granted. The next slot then starts a new round at the lowest-indexed ready high-priority channel.
- R6: The low-priority search starts at the channel just after the last granted low-priority channel and wraps from the highest index back to 0. This pointer persists across rounds.
- R7: With every priority bit at 0, all ready channels are granted on consecutive slots in round-robin order.
- R8: With no low-priority channel ready, the ready high-priority channels are granted in repeating ascending passes, with no idle slot between passes.
- R9: A high-priority channel that becomes ready at an index below the round pointer waits for the next round. It is therefore granted only after one low-priority channel, if one is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one issue slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| chReady | input | NUM_CH | Per-channel request to issue a transfer |
| chHighPri | input | NUM_CH | Per-channel priority bit, 1 = high group |
| grantValid | output | 1 | A grant is issued in this slot |
| grantOneHot | output | NUM_CH | One-hot select of the granted channel |

## Verification
The only state is the round pointer and the low-priority rotation pointer, and an error in either shows up at the grant port within one round. A round pointer that is reset or advanced wrongly shows a low-priority channel granted while a high-priority channel still waits ahead, or a high-priority channel granted twice in a round. A wrong rotation pointer shows the same low-priority channel returning instead of the next one in turn, which becomes visible at the second low-priority grant.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  // Decision strobes from control to datapath, at most one set per slot
  typedef struct packed {
    logic takeHi;    // next high channel at or above the round pointer
    logic takeLo;    // one low channel, closes the round
    logic takeWrap;  // no low ready: restart the high group from index 0
  } schedStrobe_t;
endpackage

// File: rtl/dma_sched_control.sv
module dma_sched_control
  import dma_sched_pkg::*;
(
  input  logic         hiFound,
  input  logic         loFound,
  input  logic         wrapFound,
  output schedStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (hiFound)        strobe.takeHi   = 1'b1;
    else if (loFound)   strobe.takeLo   = 1'b1;
    else if (wrapFound) strobe.takeWrap = 1'b1;
  end
endmodule

// File: rtl/dma_sched_datapath.sv
module dma_sched_datapath
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReady,
  input  logic [NUM_CH-1:0] chHighPri,
  input  schedStrobe_t      strobe,
  output logic              hiFound,
  output logic              loFound,
  output logic              wrapFound,
  output logic              grantValid,
  output logic [NUM_CH-1:0] grantOneHot
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PTR_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] hiMask, loMask;
  logic [PTR_W-1:0]  hiPtr;
  logic [IDX_W-1:0]  loPtr;
  logic [IDX_W-1:0]  hiIdx, loIdx, wrapIdx, selIdx;

  for (genvar g = 0; g < NUM_CH; g++) begin : gMask
    assign hiMask[g] = chReady[g] &  chHighPri[g];
    assign loMask[g] = chReady[g] & ~chHighPri[g];
  end

  // Lowest ready high channel at or above the round pointer
  always_comb begin
    hiFound = 1'b0;
    hiIdx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hiMask[i] && (i >= int'(hiPtr))) begin
        hiFound = 1'b1;
        hiIdx   = IDX_W'(i);
      end
    end
  end

  // Lowest ready high channel overall, used to open a new round
  always_comb begin
    wrapFound = 1'b0;
    wrapIdx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hiMask[i]) begin
        wrapFound = 1'b1;
        wrapIdx   = IDX_W'(i);
      end
    end
  end

  // First ready low channel counting up from the rotation pointer
  always_comb begin
    int j;
    loFound = 1'b0;
    loIdx   = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      j = int'(loPtr) + k;
      if (j >= NUM_CH) j = j - NUM_CH;
      if (loMask[j]) begin
        loFound = 1'b1;
        loIdx   = IDX_W'(j);
      end
    end
  end

  always_comb begin
    if (strobe.takeHi)      selIdx = hiIdx;
    else if (strobe.takeLo) selIdx = loIdx;
    else                    selIdx = wrapIdx;
    grantValid  = rstN & (strobe.takeHi | strobe.takeLo | strobe.takeWrap);
    grantOneHot = grantValid ? (NUM_CH'(1) << selIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiPtr <= '0;
      loPtr <= '0;
    end else if (strobe.takeHi) begin
      hiPtr <= PTR_W'(hiIdx) + PTR_W'(1);
    end else if (strobe.takeLo) begin
      hiPtr <= '0;
      loPtr <= (int'(loIdx) == NUM_CH - 1) ? '0 : loIdx + IDX_W'(1);
    end else if (strobe.takeWrap) begin
      hiPtr <= PTR_W'(wrapIdx) + PTR_W'(1);
    end
  end
endmodule

// File: rtl/dma_issue_sched.sv
module dma_issue_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReady,
  input  logic [NUM_CH-1:0] chHighPri,
  output logic              grantValid,
  output logic [NUM_CH-1:0] grantOneHot
);
  schedStrobe_t strobe;
  logic hiFound, loFound, wrapFound;

  dma_sched_control u_control (
    .hiFound   (hiFound),
    .loFound   (loFound),
    .wrapFound (wrapFound),
    .strobe    (strobe)
  );

  dma_sched_datapath #(.NUM_CH(NUM_CH)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .chReady     (chReady),
    .chHighPri   (chHighPri),
    .strobe      (strobe),
    .hiFound     (hiFound),
    .loFound     (loFound),
    .wrapFound   (wrapFound),
    .grantValid  (grantValid),
    .grantOneHot (grantOneHot)
  );
endmodule

// File: rtl/dma_issue_sched_checker.sv
module dma_issue_sched_checker #(
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chReady,
  input logic [NUM_CH-1:0] chHighPri,
  input logic              grantValid,
  input logic [NUM_CH-1:0] grantOneHot
);
  logic pastValid;
  logic lowGrant, highGrant;

  always_ff @(posedge clk) pastValid <= rstN;

  assign lowGrant  = grantValid && |(grantOneHot & ~chHighPri);
  assign highGrant = grantValid && |(grantOneHot &  chHighPri);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!grantValid && grantOneHot == '0));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot) && (grantValid == |grantOneHot));

  assert_grant_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot & ~chReady) == '0);

  assert_no_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == |chReady);

  assert_round_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(lowGrant) && |(chReady & chHighPri)) |-> highGrant);
endmodule

bind dma_issue_sched dma_issue_sched_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .chReady     (chReady),
  .chHighPri   (chHighPri),
  .grantValid  (grantValid),
  .grantOneHot (grantOneHot)
);

// File: tb/dma_issue_sched_bench.sv
`timescale 1ns/1ps
module dma_issue_sched_bench;
  localparam int N = 5;
  localparam int NV = 34;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] chReady = '0;
  logic [N-1:0] chHighPri = '0;
  logic         grantValid;
  logic [N-1:0] grantOneHot;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_issue_sched #(.NUM_CH(N)) u_dma_issue_sched (
    .clk(clk), .rstN(rstN), .chReady(chReady), .chHighPri(chHighPri),
    .grantValid(grantValid), .grantOneHot(grantOneHot)
  );

  // {ready, highPri, expected grant}, applied one slot each after reset
  localparam logic [14:0] VECS [0:NV-1] = '{
    15'b11111_00011_00001, 15'b11111_00011_00010, 15'b11111_00011_00100,
    15'b11111_00011_00001, 15'b11111_00011_00010, 15'b11111_00011_01000,
    15'b11111_00011_00001, 15'b11111_00011_00010, 15'b11111_00011_10000,
    15'b11111_00011_00001, 15'b11111_00011_00010, 15'b11111_00011_00100,
    15'b00000_00011_00000,
    15'b11100_00011_01000, 15'b11100_00011_10000, 15'b11100_00011_00100,
    15'b00011_00011_00001, 15'b00011_00011_00010,
    15'b00011_00011_00001, 15'b00011_00011_00010,
    15'b11111_00011_01000, 15'b11111_00011_00001,
    15'b10001_00011_10000, 15'b10001_00011_00001,
    15'b11111_00000_00001, 15'b11111_00000_00010, 15'b11111_00000_00100,
    15'b11111_00000_01000, 15'b11111_00000_10000, 15'b11111_00000_00001,
    15'b11111_10000_10000, 15'b11111_10000_00010,
    15'b11111_10000_10000, 15'b11111_10000_00100
  };

  function automatic string reqOf(int i);
    if (i < 12)      return "R4/R5/R6";
    else if (i < 13) return "R3";
    else if (i < 16) return "R6";
    else if (i < 20) return "R8";
    else if (i < 22) return "R5";
    else if (i < 24) return "R9";
    else if (i < 30) return "R7";
    else             return "R4/R6";
  endfunction

  task automatic check(string req, logic [N-1:0] expGrant);
    checks++;
    if (grantOneHot !== expGrant || grantValid !== (|expGrant)) begin
      fails++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               req, grantOneHot, grantValid, expGrant, |expGrant);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during reset even with requests present
    chReady = 5'b11111; chHighPri = 5'b00011;
    repeat (2) @(negedge clk);
    #1 check("R1", 5'b00000);
    @(negedge clk); rstN = 1'b1;

    // Table walk; the first entry also confirms R1 pointer start at 0
    for (int i = 0; i < NV; i++) begin
      if (i > 0) @(negedge clk);
      chReady   = VECS[i][14:10];
      chHighPri = VECS[i][9:5];
      #1 check(reqOf(i), VECS[i][4:0]);
    end

    // R1: reset mid-run restores the low rotation pointer to channel 0
    @(negedge clk); rstN = 1'b0;
    chReady = 5'b11100; chHighPri = 5'b00011;
    #1 check("R1", 5'b00000);
    @(negedge clk); rstN = 1'b1;
    #1 check("R1", 5'b00100);

    // R3/R2: a single ready channel is granted every slot
    @(negedge clk); chReady = 5'b01000;
    #1 check("R2", 5'b01000);
    @(negedge clk);
    #1 check("R3", 5'b01000);
    @(negedge clk); chReady = 5'b00000;
    #1 check("R3", 5'b00000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule